// File: doc/BRIEF.md
# Breakpoint and Branch Trace Unit

This debug block sits beside a processor core and watches the stream of executed instruction addresses. Four address comparators, each with its own enable, flag a fetch whose address equals a programmed value. A preset down-counter decides when such events become a trap. In one mode it counts comparator hits. In the other it counts fetches marked as coming from the instruction cache. When the count runs out, the block sends a one-cycle trap request to the core and the same pulse on a line shared with other processors. A rising trap line from another processor also traps this core.

The block also follows program flow. Whenever a valid fetch address is not the previous valid fetch address plus one, it stores the pair (last address before the jump, first address after it) in a four-slot circular buffer. A readable pointer marks the slot that will be overwritten next. Software reaches every register through a single-cycle write strobe with a combinational read port.

Register map (4-bit address): 0 to 3 hold the comparator addresses. 4 is control: bits [3:0] enable comparators 0 to 3, and bit 4 selects cache-instruction counting (1) or hit counting (0). 5 is the counter: a write presets and arms it, a read returns the remaining count. 6 is the trace pointer (read only). 8 to 11 hold the "before" address of trace slots 0 to 3. 12 to 15 hold the "after" address of those slots. Writes to 6 and 8 to 15 do nothing.

Top module: `bkpt_trace_unit`

## Requirements
- R1: Each of the four comparators signals a hit on a valid fetch whose address equals its register (addresses 0 to 3), provided its enable bit (control bit k) is set.
- R2: A comparator whose enable bit is clear never counts, even when the fetch address matches.
- R3: In hit mode (control bit 4 = 0), a counter preset to N (N >= 1) raises trap_o in the cycle after the Nth counted fetch edge and not before. A preset of 0 behaves like 1. Each earlier counted event lowers the value read at address 5 by one.
- R4: In cache mode (control bit 4 = 1), only valid fetches with cache_instr_i high are counted, and comparator hits are ignored.
- R5: trap_o from the counter is a one-cycle pulse. Afterwards the counter reads 0 and no further counter trap occurs until address 5 is written again. After reset the counter is disarmed.
- R6: A rising edge on trap_in_i produces a one-cycle trap_o pulse in the next cycle, whatever the counter state. It does not assert trap_out_o.
- R7: trap_out_o pulses in exactly the cycles in which the counter raises trap_o.
- R8: A valid fetch whose address differs from the previous valid fetch address plus one (modulo 2^16) stores the previous address at address 8+p and the new address at address 12+p, where p is the pointer value. The pointer then advances. The first valid fetch after reset stores nothing.
- R9: The pointer (address 6) counts modulo 4, so the fifth discontinuity overwrites the oldest pair. The pointer changes only on a valid fetch.
- R10: After reset every readable register is 0, and trap_o and trap_out_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 16 | Executed instruction address |
| pc_valid_i | input | 1 | pc_i holds a valid executed fetch |
| cache_instr_i | input | 1 | Fetch was served from the instruction cache |
| trap_in_i | input | 1 | Trap line from other processors |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| trap_o | output | 1 | One-cycle trap request to the core |
| trap_out_o | output | 1 | One-cycle trap to other processors |

## Verification
The bench targets the exact count boundary. A counter that is off by one traps one hit early or late, and one that treats a preset of 0 as a very large count never traps. It fetches a matching address at a disabled slot and, in cache mode, fetches a matching address that is not a cache instruction; a design that ignores the enable or mixes up the modes counts these. It also re-fetches a breakpoint after a trap, to catch a counter that wraps and re-arms by itself. A golden model of the trace runs through more than four jumps, including repeated same-address fetches. This exposes a wrong "plus one" test, a pointer that does not wrap, swapped before/after fields, or an entry recorded on the first fetch after reset.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int REG_AW = 4;
  // low half of map: addr[2]=0 -> comparators, addr[2]=1 -> control regs
  localparam logic [1:0] SUB_CTRL = 2'd0;
  localparam logic [1:0] SUB_CNT  = 2'd1;
  localparam logic [1:0] SUB_TPTR = 2'd2;
  localparam int CTRL_MODE_BIT = 4;
endpackage

// File: rtl/bkpt_match.sv
module bkpt_match #(
  parameter int ADDR_W = 16,
  parameter int NUM_BP = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_BP-1:0]              we_i,
  input  logic [ADDR_W-1:0]              wdata_i,
  input  logic [NUM_BP-1:0]              en_i,
  input  logic [ADDR_W-1:0]              pc_i,
  input  logic                           pc_valid_i,
  output logic                           hit_o,
  output logic [NUM_BP-1:0][ADDR_W-1:0]  bp_addr_o
);
  logic [NUM_BP-1:0] match;

  for (genvar k = 0; k < NUM_BP; k++) begin : g_bp
    logic [ADDR_W-1:0] addr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    addr_q <= '0;
      else if (we_i[k]) addr_q <= wdata_i;
    end
    assign match[k]     = pc_valid_i & en_i[k] & (addr_q == pc_i);
    assign bp_addr_o[k] = addr_q;
  end

  assign hit_o = |match;
endmodule

// File: rtl/bkpt_counter.sv
module bkpt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             event_i,
  output logic             fire_o,
  output logic             armed_o,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q;
  logic             armed_q;
  logic             last;

  assign last   = (count_q <= CNT_W'(1));
  assign fire_o = event_i & armed_q & ~load_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      count_q <= load_val_i;
      armed_q <= 1'b1;
    end else if (event_i && armed_q) begin
      if (last) begin
        count_q <= '0;
        armed_q <= 1'b0;
      end else begin
        count_q <= count_q - CNT_W'(1);
      end
    end
  end

  assign armed_o = armed_q;
  assign count_o = count_q;
endmodule

// File: rtl/bkpt_trace_buf.sv
module bkpt_trace_buf #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             pc_i,
  input  logic                          pc_valid_i,
  output logic [DEPTH-1:0][ADDR_W-1:0]  from_o,
  output logic [DEPTH-1:0][ADDR_W-1:0]  to_o,
  output logic [PTR_W-1:0]              wptr_o
);
  logic [ADDR_W-1:0] prev_q;
  logic              have_prev_q;
  logic [PTR_W-1:0]  wptr_q;
  logic              jump;

  assign jump = pc_valid_i & have_prev_q & (pc_i != prev_q + ADDR_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      wptr_q      <= '0;
    end else if (pc_valid_i) begin
      prev_q      <= pc_i;
      have_prev_q <= 1'b1;
      if (jump) wptr_q <= (int'(wptr_q) == DEPTH - 1) ? '0 : wptr_q + PTR_W'(1);
    end
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        from_o[k] <= '0;
        to_o[k]   <= '0;
      end else if (jump && int'(wptr_q) == k) begin
        from_o[k] <= prev_q;
        to_o[k]   <= pc_i;
      end
    end
  end

  assign wptr_o = wptr_q;
endmodule

// File: rtl/bkpt_trace_unit.sv
module bkpt_trace_unit #(
  parameter int ADDR_W      = 16,
  parameter int NUM_BP      = 4,
  parameter int TRACE_DEPTH = 4,
  parameter int CNT_W       = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          pc_i,
  input  logic                       pc_valid_i,
  input  logic                       cache_instr_i,
  input  logic                       trap_in_i,
  input  logic                       reg_we_i,
  input  logic [bkpt_pkg::REG_AW-1:0] reg_addr_i,
  input  logic [ADDR_W-1:0]          reg_wdata_i,
  output logic [ADDR_W-1:0]          reg_rdata_o,
  output logic                       trap_o,
  output logic                       trap_out_o
);
  import bkpt_pkg::*;
  localparam int PTR_W = $clog2(TRACE_DEPTH);

  logic [NUM_BP-1:0]                 en_q;
  logic                              mode_q;
  logic [NUM_BP-1:0]                 bp_we;
  logic [NUM_BP-1:0][ADDR_W-1:0]     bp_addr;
  logic [TRACE_DEPTH-1:0][ADDR_W-1:0] tr_from, tr_to;
  logic [PTR_W-1:0]                  tptr_w;
  logic [CNT_W-1:0]                  count_w;
  logic                              hit, ev, fire, armed_w, cnt_load, ctrl_we;
  logic                              trap_in_q;
  logic [1:0]                        sub;

  assign sub      = reg_addr_i[1:0];
  assign ctrl_we  = reg_we_i & (reg_addr_i[3:2] == 2'b01) & (sub == SUB_CTRL);
  assign cnt_load = reg_we_i & (reg_addr_i[3:2] == 2'b01) & (sub == SUB_CNT);

  always_comb begin
    for (int k = 0; k < NUM_BP; k++)
      bp_we[k] = reg_we_i & (reg_addr_i[3:2] == 2'b00) & (int'(sub) == k);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mode_q <= 1'b0;
    end else if (ctrl_we) begin
      en_q   <= reg_wdata_i[NUM_BP-1:0];
      mode_q <= reg_wdata_i[CTRL_MODE_BIT];
    end
  end

  bkpt_match #(.ADDR_W(ADDR_W), .NUM_BP(NUM_BP)) match_i (
    .clk_i, .rst_ni, .we_i(bp_we), .wdata_i(reg_wdata_i), .en_i(en_q),
    .pc_i, .pc_valid_i, .hit_o(hit), .bp_addr_o(bp_addr)
  );

  assign ev = mode_q ? (pc_valid_i & cache_instr_i) : hit;

  bkpt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk_i, .rst_ni, .load_i(cnt_load), .load_val_i(reg_wdata_i[CNT_W-1:0]),
    .event_i(ev), .fire_o(fire), .armed_o(armed_w), .count_o(count_w)
  );

  bkpt_trace_buf #(.ADDR_W(ADDR_W), .DEPTH(TRACE_DEPTH)) trace_i (
    .clk_i, .rst_ni, .pc_i, .pc_valid_i,
    .from_o(tr_from), .to_o(tr_to), .wptr_o(tptr_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_in_q  <= 1'b0;
      trap_o     <= 1'b0;
      trap_out_o <= 1'b0;
    end else begin
      trap_in_q  <= trap_in_i;
      trap_o     <= fire | (trap_in_i & ~trap_in_q);
      trap_out_o <= fire;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i[3]) begin
      if (int'(sub) < TRACE_DEPTH)
        reg_rdata_o = reg_addr_i[2] ? tr_to[sub] : tr_from[sub];
    end else if (!reg_addr_i[2]) begin
      if (int'(sub) < NUM_BP) reg_rdata_o = bp_addr[sub];
    end else begin
      case (sub)
        SUB_CTRL: begin
          reg_rdata_o[NUM_BP-1:0]     = en_q;
          reg_rdata_o[CTRL_MODE_BIT]  = mode_q;
        end
        SUB_CNT:  reg_rdata_o = ADDR_W'(count_w);
        SUB_TPTR: reg_rdata_o = ADDR_W'(tptr_w);
        default:  reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/bkpt_trace_unit_chk.sv
module bkpt_trace_unit_chk #(
  parameter int PTR_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pc_valid_i,
  input logic             trap_in_i,
  input logic             trap_o,
  input logic             trap_out_o,
  input logic             armed_w,
  input logic [PTR_W-1:0] tptr_w
);
  assert_trap_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_out_o |=> !trap_out_o);

  assert_disarm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_out_o |-> !armed_w);

  assert_fire_on_fetch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_out_o |-> $past(pc_valid_i));

  assert_out_implies_trap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_out_o |-> trap_o);

  assert_trap_in_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trap_in_i) |=> trap_o);

  assert_ptr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_valid_i |=> $stable(tptr_w));
endmodule

bind bkpt_trace_unit bkpt_trace_unit_chk #(.PTR_W(PTR_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .pc_valid_i(pc_valid_i), .trap_in_i(trap_in_i),
  .trap_o(trap_o), .trap_out_o(trap_out_o), .armed_w(armed_w), .tptr_w(tptr_w)
);

// File: tb/bkpt_trace_unit_tb_top.sv
module bkpt_trace_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] pc_i = '0;
  logic        pc_valid_i = 1'b0, cache_instr_i = 1'b0, trap_in_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        trap_o, trap_out_o;

  int checks = 0, errors = 0;
  logic [15:0] m_from [4];
  logic [15:0] m_to [4];
  int          m_ptr = 0;
  logic [15:0] m_prev = '0;
  bit          m_have = 0;

  always #2 clk_i = ~clk_i;

  bkpt_trace_unit dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a; #1;
    d = reg_rdata_o;
  endtask

  task automatic fetch(logic [15:0] pc, bit cache, output bit trp, output bit tout);
    @(negedge clk_i);
    pc_i = pc; pc_valid_i = 1'b1; cache_instr_i = cache;
    if (m_have && pc != 16'(m_prev + 16'd1)) begin
      m_from[m_ptr] = m_prev; m_to[m_ptr] = pc; m_ptr = (m_ptr + 1) % 4;
    end
    m_prev = pc; m_have = 1;
    @(posedge clk_i); #1;
    trp = trap_o; tout = trap_out_o;
    pc_valid_i = 1'b0; cache_instr_i = 1'b0;
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R10 trap_o", trap_o, 0);
    chk("R10 trap_out_o", trap_out_o, 0);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk($sformatf("R10 reg %0d", a), d, 0);
    end
  endtask

  task automatic t_hit_count();
    logic [15:0] d; bit t, o;
    wr(0, 16'h0100); wr(2, 16'h0200); wr(4, 16'h0001); wr(5, 16'd3);
    fetch(16'h0100, 0, t, o); chk("R3 first hit no trap", t, 0);
    rd(5, d); chk("R3 count after one hit", d, 2);
    rd(6, d); chk("R8 first fetch not traced", d, 0);
    fetch(16'h0200, 0, t, o); chk("R2 disabled slot no trap", t, 0);
    rd(5, d); chk("R2 disabled slot not counted", d, 2);
    fetch(16'h0100, 0, t, o); chk("R3 second hit no trap", t, 0);
    fetch(16'h0100, 0, t, o); chk("R3 third hit traps", t, 1);
    chk("R7 trap_out with local trap", o, 1);
    @(posedge clk_i); #1; chk("R5 trap one cycle", trap_o, 0);
    chk("R7 trap_out one cycle", trap_out_o, 0);
    fetch(16'h0100, 0, t, o); chk("R5 no trap until rearm", t, 0);
    rd(5, d); chk("R5 count reads zero", d, 0);
    wr(4, 16'h0004); wr(5, 16'd1);
    fetch(16'h0200, 0, t, o); chk("R1 slot2 preset 1 traps", t, 1);
    wr(3, 16'h0300); wr(4, 16'h0008); wr(5, 16'd0);
    fetch(16'h0300, 0, t, o); chk("R3 preset zero traps on first hit", t, 1);
    wr(1, 16'h0110); wr(4, 16'h0002); wr(5, 16'd2);
    fetch(16'h0110, 0, t, o); chk("R1 slot1 first hit", t, 0);
    fetch(16'h0110, 0, t, o); chk("R1 slot1 second hit traps", t, 1);
    rd(4, d); chk("R1 control readback", d, 16'h0002);
  endtask

  task automatic t_cache_mode();
    bit t, o;
    wr(4, 16'h0011); wr(5, 16'd2);
    fetch(16'h0100, 0, t, o); chk("R4 bp hit ignored in cache mode", t, 0);
    fetch(16'h0500, 1, t, o); chk("R4 first cache instr", t, 0);
    fetch(16'h0501, 1, t, o); chk("R4 second cache instr traps", t, 1);
    chk("R7 trap_out in cache mode", o, 1);
    wr(4, 16'h0000);
  endtask

  task automatic t_trap_in();
    @(negedge clk_i); trap_in_i = 1'b1;
    @(posedge clk_i); #1;
    chk("R6 trap_in traps", trap_o, 1);
    chk("R6 trap_in no trap_out", trap_out_o, 0);
    @(posedge clk_i); #1;
    chk("R6 trap_in pulse one cycle", trap_o, 0);
    @(negedge clk_i); trap_in_i = 1'b0;
  endtask

  task automatic t_trace();
    logic [15:0] d; bit t, o;
    logic [15:0] seq [10] = '{16'h1000, 16'h1001, 16'h1002, 16'h2000, 16'h2001,
                              16'h3000, 16'h4000, 16'h4001, 16'h5000, 16'h6000};
    foreach (seq[i]) fetch(seq[i], 0, t, o);
    @(negedge clk_i); @(negedge clk_i);
    rd(6, d); chk("R9 pointer modulo 4", d, 16'(m_ptr));
    for (int k = 0; k < 4; k++) begin
      rd(4'(8 + k), d);  chk($sformatf("R8 before addr slot %0d", k), d, m_from[k]);
      rd(4'(12 + k), d); chk($sformatf("R8 after addr slot %0d", k), d, m_to[k]);
    end
    fetch(16'h6001, 0, t, o);
    rd(6, d); chk("R9 sequential fetch keeps pointer", d, 16'(m_ptr));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    t_reset();
    t_hit_count();
    t_cache_mode();
    t_trap_in();
    t_trace();
    report();
  end
endmodule